// File: doc/BRIEF.md
# Cascadable Pipelined Signed Multiplier Slice

The slice forms the full-precision product of two 18-bit two's-complement operands. The first operand always comes from a local port. The second operand comes from one of two places, fixed when the slice is elaborated: its own local port, or a cascade port driven by a neighbouring slice.

Each operand path and the product path has a pipeline stage that can be left out. Each stage has its own clock enable and its own synchronous reset, and all stages share one clock.

The operand that actually reaches the multiplier's second input is also driven onto a cascade output. When the second-operand stage is present, that value is taken after the stage. Several slices can therefore be chained so that they all multiply against one shared second operand.

Top module: `mul_slice`

## Requirements
- R1: `prod` is the 36-bit signed product of `a_in` and the applied second operand, with both operands read as 18-bit two's-complement values. The extreme case -131072 × -131072 gives +2^34.
- R2: With `B_SRC = SRC_DIRECT` (enum value 0), the second operand is taken from `b_in`, and `b_casc_in` has no effect on any output.
- R3: With `B_SRC = SRC_CASCADE` (enum value 1), the second operand is taken from `b_casc_in`, and `b_in` has no effect on any output.
- R4: `b_casc_out` always equals the operand applied to the multiplier's second input. That is the selected source when `B_STAGE = 0`, and the second-operand register when `B_STAGE = 1`.
- R5: A present stage loads its input on a rising `clk` edge when its enable is high and its reset is low. Otherwise it holds its value.
- R6: A present stage's reset is synchronous and active high. It clears the stage to zero on the next rising edge, whatever the state of its enable.
- R7: When a stage's parameter is 0, that path is combinational, and the stage's enable and reset have no effect.
- R8: A change on an operand port reaches `prod` after as many edges as there are present stages in that operand's path plus the product stage: 0, 1 or 2.
- R9: In a chain, a slice built with `SRC_CASCADE` whose `b_casc_in` is driven by an upstream slice's `b_casc_out` multiplies by exactly the operand that the upstream slice applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all stages |
| a_in | input | 18 | First operand, signed |
| b_in | input | 18 | Local second operand, signed |
| b_casc_in | input | 18 | Second operand from an upstream slice |
| ce_a | input | 1 | Enable of the first-operand stage |
| ce_b | input | 1 | Enable of the second-operand stage |
| ce_p | input | 1 | Enable of the product stage |
| rst_a | input | 1 | Synchronous clear of the first-operand stage |
| rst_b | input | 1 | Synchronous clear of the second-operand stage |
| rst_p | input | 1 | Synchronous clear of the product stage |
| b_casc_out | output | 18 | Applied second operand, for a downstream slice |
| prod | output | 36 | Signed product |

## Verification
The bench builds eight two-slice chains, one for each setting of `A_STAGE`, `B_STAGE` and `P_STAGE`. In every chain the head slice uses `SRC_DIRECT` and the tail slice uses `SRC_CASCADE`, so all sixteen parameter combinations are elaborated, including the four second-operand path variants.

Driving every chain from one shared stimulus places latencies of 0, 1 and 2 edges side by side. The same stimulus covers a head slice with no second-operand stage passing its operand straight to the tail, and a registered cascade that adds one edge to the tail's operand.

The unused source port of each slice is tied to moving data, which shows that it is ignored.

// File: rtl/mslice_pkg.sv
package mslice_pkg;

    typedef enum logic {
        SRC_DIRECT  = 1'b0,
        SRC_CASCADE = 1'b1
    } bsrc_e;

    typedef struct packed {
        logic ce;
        logic clr;
    } stage_ctl_t;

endpackage

// File: rtl/msl_stage.sv
module msl_stage #(
    parameter int W       = 18,
    parameter bit PRESENT = 1'b1
) (
    input  logic                    clk,
    input  mslice_pkg::stage_ctl_t  ctl,
    input  logic [W-1:0]            din,
    output logic [W-1:0]            dout
);

    typedef struct packed {
        logic [W-1:0] val;
    } st_t;

    st_t r_d, r_q;

    // clear wins over enable
    always_comb begin
        r_d = r_q;
        if (ctl.clr) begin
            r_d.val = '0;
        end else if (ctl.ce) begin
            r_d.val = din;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    generate
        if (PRESENT) begin : g_reg
            assign dout = r_q.val;
        end else begin : g_wire
            assign dout = din;
        end
    endgenerate

endmodule

// File: rtl/msl_bsrc.sv
module msl_bsrc #(
    parameter int               W   = 18,
    parameter mslice_pkg::bsrc_e SRC = mslice_pkg::SRC_DIRECT
) (
    input  logic [W-1:0] b_loc,
    input  logic [W-1:0] b_chain,
    output logic [W-1:0] b_sel
);

    generate
        if (SRC == mslice_pkg::SRC_CASCADE) begin : g_chain
            assign b_sel = b_chain;
        end else begin : g_local
            assign b_sel = b_loc;
        end
    endgenerate

endmodule

// File: rtl/msl_mul.sv
module msl_mul #(
    parameter int AW = 18,
    parameter int BW = 18,
    localparam int PW = AW + BW
) (
    input  logic [AW-1:0] op_a,
    input  logic [BW-1:0] op_b,
    output logic [PW-1:0] prod_c
);

    logic signed [PW-1:0] full;

    always_comb begin
        full   = PW'($signed(op_a)) * PW'($signed(op_b));
        prod_c = full;
    end

endmodule

// File: rtl/mul_slice.sv
module mul_slice
    import mslice_pkg::*;
#(
    parameter int    A_W     = 18,
    parameter int    B_W     = 18,
    parameter bsrc_e B_SRC   = SRC_DIRECT,
    parameter bit    A_STAGE = 1'b1,
    parameter bit    B_STAGE = 1'b1,
    parameter bit    P_STAGE = 1'b1,
    localparam int   P_W     = A_W + B_W
) (
    input  logic           clk,
    input  logic [A_W-1:0] a_in,
    input  logic [B_W-1:0] b_in,
    input  logic [B_W-1:0] b_casc_in,
    input  logic           ce_a,
    input  logic           ce_b,
    input  logic           ce_p,
    input  logic           rst_a,
    input  logic           rst_b,
    input  logic           rst_p,
    output logic [B_W-1:0] b_casc_out,
    output logic [P_W-1:0] prod
);

    stage_ctl_t     ctl_a, ctl_b, ctl_p;
    logic [B_W-1:0] b_src;
    logic [B_W-1:0] b_app;
    logic [A_W-1:0] a_app;
    logic [P_W-1:0] prod_c;

    always_comb begin
        ctl_a = '{ce: ce_a, clr: rst_a};
        ctl_b = '{ce: ce_b, clr: rst_b};
        ctl_p = '{ce: ce_p, clr: rst_p};
    end

    msl_bsrc #(.W(B_W), .SRC(B_SRC)) u_bsrc (
        .b_loc   (b_in),
        .b_chain (b_casc_in),
        .b_sel   (b_src)
    );

    msl_stage #(.W(B_W), .PRESENT(B_STAGE)) u_bstg (
        .clk  (clk),
        .ctl  (ctl_b),
        .din  (b_src),
        .dout (b_app)
    );

    msl_stage #(.W(A_W), .PRESENT(A_STAGE)) u_astg (
        .clk  (clk),
        .ctl  (ctl_a),
        .din  (a_in),
        .dout (a_app)
    );

    msl_mul #(.AW(A_W), .BW(B_W)) u_mul (
        .op_a   (a_app),
        .op_b   (b_app),
        .prod_c (prod_c)
    );

    msl_stage #(.W(P_W), .PRESENT(P_STAGE)) u_pstg (
        .clk  (clk),
        .ctl  (ctl_p),
        .din  (prod_c),
        .dout (prod)
    );

    // the cascade tap sits after the optional operand stage
    assign b_casc_out = b_app;

endmodule

// File: rtl/mul_slice_chk.sv
module mul_slice_chk
    import mslice_pkg::*;
#(
    parameter int    A_W     = 18,
    parameter int    B_W     = 18,
    parameter bsrc_e B_SRC   = SRC_DIRECT,
    parameter bit    A_STAGE = 1'b1,
    parameter bit    B_STAGE = 1'b1,
    parameter bit    P_STAGE = 1'b1,
    localparam int   P_W     = A_W + B_W
) (
    input logic           clk,
    input logic [A_W-1:0] a_in,
    input logic [B_W-1:0] b_in,
    input logic [B_W-1:0] b_casc_in,
    input logic           ce_a,
    input logic           ce_b,
    input logic           ce_p,
    input logic           rst_a,
    input logic           rst_b,
    input logic           rst_p,
    input logic [B_W-1:0] b_casc_out,
    input logic [P_W-1:0] prod
);

    logic live_q = 1'b0;
    always_ff @(posedge clk) live_q <= 1'b1;

    logic [B_W-1:0] src_w;
    logic [P_W-1:0] ref_w;
    assign src_w = (B_SRC == SRC_CASCADE) ? b_casc_in : b_in;
    assign ref_w = P_W'($signed(a_in)) * P_W'($signed(src_w));

    wire unused_chk = ^{ce_a, rst_a, ce_b, rst_b, ce_p, rst_p, ref_w, prod};

    generate
        if (!B_STAGE) begin : g_bpass
            AST_CASC_PASS: assert property (@(posedge clk) disable iff (!live_q)
                b_casc_out == src_w); // R4
        end else begin : g_breg
            AST_BREG_CLR: assert property (@(posedge clk) disable iff (!live_q)
                rst_b |=> b_casc_out == '0); // R6
            AST_BREG_LOAD: assert property (@(posedge clk) disable iff (!live_q)
                (!rst_b && ce_b) |=> b_casc_out == $past(src_w)); // R5
            AST_BREG_HOLD: assert property (@(posedge clk) disable iff (!live_q)
                (!rst_b && !ce_b) |=> $stable(b_casc_out)); // R5
        end

        if (P_STAGE) begin : g_preg
            AST_PREG_CLR: assert property (@(posedge clk) disable iff (!live_q)
                rst_p |=> prod == '0); // R6
            AST_PREG_HOLD: assert property (@(posedge clk) disable iff (!live_q)
                (!rst_p && !ce_p) |=> $stable(prod)); // R5
        end

        if (!A_STAGE && !B_STAGE && !P_STAGE) begin : g_comb
            AST_PROD_COMB: assert property (@(posedge clk) disable iff (!live_q)
                prod == ref_w); // R1
        end
    endgenerate

endmodule

bind mul_slice mul_slice_chk #(
    .A_W(A_W), .B_W(B_W), .B_SRC(B_SRC),
    .A_STAGE(A_STAGE), .B_STAGE(B_STAGE), .P_STAGE(P_STAGE)
) u_chk (
    .clk(clk), .a_in(a_in), .b_in(b_in), .b_casc_in(b_casc_in),
    .ce_a(ce_a), .ce_b(ce_b), .ce_p(ce_p),
    .rst_a(rst_a), .rst_b(rst_b), .rst_p(rst_p),
    .b_casc_out(b_casc_out), .prod(prod)
);

// File: tb/mul_slice_test.sv
`timescale 1ns/1ps
module mul_slice_test;
    import mslice_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [17:0] a_in = '0, b_in = '0;
    logic ce_a = 1'b0, ce_b = 1'b0, ce_p = 1'b0;
    logic rst_a = 1'b1, rst_b = 1'b1, rst_p = 1'b1;

    logic [17:0] cu [8];
    logic [17:0] cd [8];
    logic [35:0] pu [8];
    logic [35:0] pd [8];

    // head slice: local operand; tail slice: cascaded operand
    // each unused source is tied to moving data (R2, R3)
    for (genvar k = 0; k < 8; k++) begin : g_cfg
        mul_slice #(.B_SRC(SRC_DIRECT), .A_STAGE(k[0]), .B_STAGE(k[1]),
                    .P_STAGE(k[2])) uut (
            .clk(clk), .a_in(a_in), .b_in(b_in), .b_casc_in(~a_in),
            .ce_a(ce_a), .ce_b(ce_b), .ce_p(ce_p),
            .rst_a(rst_a), .rst_b(rst_b), .rst_p(rst_p),
            .b_casc_out(cu[k]), .prod(pu[k]));
        mul_slice #(.B_SRC(SRC_CASCADE), .A_STAGE(k[0]), .B_STAGE(k[1]),
                    .P_STAGE(k[2])) uut_tail (
            .clk(clk), .a_in(a_in), .b_in(a_in ^ b_in), .b_casc_in(cu[k]),
            .ce_a(ce_a), .ce_b(ce_b), .ce_p(ce_p),
            .rst_a(rst_a), .rst_b(rst_b), .rst_p(rst_p),
            .b_casc_out(cd[k]), .prod(pd[k]));
    end

    typedef struct {
        string       tag;
        int          k;
        logic [17:0] cu;
        logic [17:0] cd;
        logic [35:0] pu;
        logic [35:0] pd;
    } exp_t;

    exp_t q[$];
    event sample_ev;
    int   checks = 0, errors = 0;
    bit   done = 1'b0;

    // model state, one per configuration
    logic signed [17:0] m_a  [8];
    logic signed [17:0] m_bu [8];
    logic signed [17:0] m_bd [8];
    logic signed [35:0] m_pu [8];
    logic signed [35:0] m_pd [8];

    task automatic cmp(input string tag, input int k, input string what,
                       input logic [35:0] got, input logic [35:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s cfg=%0d %s actual=%h expected=%h", tag, k, what, got, exp);
        end
    endtask

    // monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            @(sample_ev);
            while (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                cmp(it.tag, it.k, "prod_head", pu[it.k], it.pu);
                cmp("R4",   it.k, "casc_head", 36'(cu[it.k]), 36'(it.cu));
                cmp("R9",   it.k, "casc_tail", 36'(cd[it.k]), 36'(it.cd));
                cmp("R9",   it.k, "prod_tail", pd[it.k], it.pd);
            end
        end
    end

    // driver: applies one cycle of stimulus, queues expectations, advances model
    task automatic step(input string tag, input bit chk,
                        input logic [17:0] a, input logic [17:0] b,
                        input bit cea, input bit ceb, input bit cep,
                        input bit ra, input bit rb, input bit rp);
        @(negedge clk);
        a_in = a; b_in = b;
        ce_a = cea; ce_b = ceb; ce_p = cep;
        rst_a = ra; rst_b = rb; rst_p = rp;
        #1;
        for (int k = 0; k < 8; k++) begin
            logic signed [17:0] aop, bu, bd;
            logic signed [35:0] cu_p, cd_p;
            exp_t it;
            aop  = k[0] ? m_a[k]  : $signed(a);
            bu   = k[1] ? m_bu[k] : $signed(b);
            bd   = k[1] ? m_bd[k] : bu;
            cu_p = aop * bu;
            cd_p = aop * bd;
            if (chk) begin
                it.tag = tag; it.k = k;
                it.cu = bu; it.cd = bd;
                it.pu = k[2] ? m_pu[k] : cu_p;
                it.pd = k[2] ? m_pd[k] : cd_p;
                q.push_back(it);
            end
            if (ra) m_a[k] = '0;       else if (cea) m_a[k] = $signed(a);
            if (rb) begin m_bu[k] = '0; m_bd[k] = '0; end
            else if (ceb) begin m_bu[k] = $signed(b); m_bd[k] = bu; end
            if (rp) begin m_pu[k] = '0; m_pd[k] = '0; end
            else if (cep) begin m_pu[k] = cu_p; m_pd[k] = cd_p; end
        end
        if (chk) -> sample_ev;
    endtask

    function automatic logic [17:0] rnd18();
        return 18'($urandom);
    endfunction

    initial begin
        for (int k = 0; k < 8; k++) begin
            m_a[k] = '0; m_bu[k] = '0; m_bd[k] = '0; m_pu[k] = '0; m_pd[k] = '0;
        end
        // bring every register to zero before checking
        step("R6", 1'b0, '0, '0, 1,1,1, 1,1,1);
        step("R6", 1'b0, '0, '0, 1,1,1, 1,1,1);
        // R6: resets with enables high keep zero
        step("R6", 1'b1, rnd18(), rnd18(), 1,1,1, 1,1,1);
        step("R6", 1'b1, rnd18(), rnd18(), 1,1,1, 1,1,1);
        // R1: extreme signed values and random products
        step("R1", 1'b1, 18'h20000, 18'h20000, 1,1,1, 0,0,0);
        step("R1", 1'b1, 18'h1FFFF, 18'h20000, 1,1,1, 0,0,0);
        step("R1", 1'b1, 18'h3FFFF, 18'h1FFFF, 1,1,1, 0,0,0);
        step("R1", 1'b1, '0, '0, 1,1,1, 0,0,0);
        for (int i = 0; i < 30; i++) step("R1", 1'b1, rnd18(), rnd18(), 1,1,1, 0,0,0);
        // R8: single impulse, then zeros, to expose 0/1/2 edge latency
        step("R8", 1'b1, 18'h00123, 18'h3FF00, 1,1,1, 0,0,0);
        for (int i = 0; i < 4; i++) step("R8", 1'b1, '0, '0, 1,1,1, 0,0,0);
        // R5: random enables, no resets
        for (int i = 0; i < 40; i++)
            step("R5", 1'b1, rnd18(), rnd18(), 1'($urandom), 1'($urandom), 1'($urandom), 0,0,0);
        // R6: reset against high enable, per stage
        step("R6", 1'b1, rnd18(), rnd18(), 1,1,1, 1,0,0);
        step("R6", 1'b1, rnd18(), rnd18(), 1,1,1, 0,1,0);
        step("R6", 1'b1, rnd18(), rnd18(), 1,1,1, 0,0,1);
        step("R6", 1'b1, rnd18(), rnd18(), 1,1,1, 0,0,0);
        // R7: random enables and resets; absent stages must be unaffected
        for (int i = 0; i < 40; i++)
            step("R7", 1'b1, rnd18(), rnd18(), 1'($urandom), 1'($urandom), 1'($urandom),
                 ($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 4) == 0);
        // R2 / R3: the unused source of each slice moves with the stimulus
        for (int i = 0; i < 20; i++) step("R2", 1'b1, rnd18(), rnd18(), 1,1,1, 0,0,0);
        for (int i = 0; i < 20; i++) step("R3", 1'b1, rnd18(), 18'h15555 ^ rnd18(), 1,1,1, 0,0,0);
        step("R3", 1'b0, '0, '0, 1,1,1, 0,0,0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule